// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Status FIFO

This block recovers serial frames from a single asynchronous receive line and hands the completed words to a consumer through a two-entry FIFO. A 16x oversampling tick, generated outside the block, paces the receiver. The line first passes through a two-flop synchronizer. Each bit value is the majority of three samples taken around the middle of its bit period. Frames carry eight data bits, least significant bit first, and an optional ninth data bit, followed by one stop bit.

Every FIFO entry stores its data byte, its ninth bit and its own framing-error flag. The head entry always drives the output fields. The output side is a valid/ready stream: `rd_valid_o` says the head entry is meaningful, and a word is consumed on a clock edge where both `rd_valid_o` and `rd_ready_i` are high. The consumer may hold `rd_ready_i` low for as long as it likes. While it does, the FIFO fills, and once both entries are taken the next completed frame raises a sticky overrun flag. No further word enters the FIFO until the receive enable is dropped and raised again. Dropping the enable also idles the receiver and flushes the FIFO. The interrupt request is the valid flag gated by an enable input.

Top module: `uart_rx_fifo_top`

## Requirements
- R1: The synchronized line is sampled only on cycles where `os_tick_i` is high. A bit lasts 16 ticks. A bit's value is the majority of the samples at ticks 7, 8 and 9 of that bit, so a disturbance covering only one of those samples does not change the received bit.
- R2: In idle, a high-to-low transition of the synchronized line, seen between two consecutive ticks, starts a frame at tick 0. If the line is high at tick 8 of the start bit, the frame is abandoned and the receiver returns to idle without writing the FIFO.
- R3: After the start bit, eight data bits arrive least significant bit first and land in `rd_data_o[0]` through `rd_data_o[7]`. When `mode9_i` is high at the start of a frame, a ninth data bit follows before the stop bit.
- R4: After the stop bit is sampled, at tick 9 of the stop bit, the word is written into the FIFO if an entry is free. The FIFO holds two words, so two frames can wait while a third is being received.
- R5: `rd_valid_o` rises only when a word is written into the FIFO, and falls only when reads empty it. A read is `rd_valid_o && rd_ready_i` on a clock edge. `rd_ready_i` while the FIFO is empty has no effect.
- R6: If the stop bit of a frame is sampled while the FIFO holds two words, `overrun_o` is set and that frame's word is discarded. This holds even if a read happens in the same cycle.
- R7: While `overrun_o` is high, no word is written into the FIFO, and `overrun_o` stays high as long as `rx_enable_i` stays high.
- R8: While `rx_enable_i` is low, the receiver stays idle, the FIFO is emptied, `overrun_o` is cleared and frames on the line are ignored.
- R9: `rd_frame_err_o` is 1 for an entry whose stop bit was sampled as 0, and 0 otherwise.
- R10: `rd_data_o`, `rd_bit9_o` and `rd_frame_err_o` show the head entry, and each read moves them to the next entry. `rd_bit9_o` is 0 for a frame received in 8-bit mode.
- R11: `irq_o` equals `rd_valid_o && irq_enable_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| os_tick_i | input | 1 | Oversampling tick, 16 per bit period |
| rx_enable_i | input | 1 | Receive enable; low idles and flushes |
| mode9_i | input | 1 | Selects 9-bit frames when high |
| irq_enable_i | input | 1 | Interrupt enable |
| rd_ready_i | input | 1 | Consumer ready; a read is taken when valid is also high |
| rd_data_o | output | 8 | Head entry data byte |
| rd_bit9_o | output | 1 | Head entry ninth data bit |
| rd_frame_err_o | output | 1 | Head entry framing error |
| rd_valid_o | output | 1 | FIFO holds at least one word |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that the FIFO never takes a write while full, that no word enters while overrun is high, and that overrun stays set while the enable is held. They also check that the valid flag rises only after a write, that a ready with an empty FIFO leaves it empty, and that a low enable clears valid and overrun. They cannot show that the right bits are recovered from the line. That needs the bench's frames: least-significant-bit-first assembly, the ninth bit, majority voting against a short glitch, rejection of a false start, framing errors kept per entry, and the order in which words come out. These are compared against a queue model in the bench.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              bit9;
    logic              ferr;
  } rx_word_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable_i,
  input  logic     rx_i,
  input  logic     tick_i,
  input  logic     mode9_i,
  output logic     done_o,
  output rx_word_t word_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam int EARLY = MID - 1;
  localparam int LATE  = MID + 1;
  localparam int SH_W  = BYTE_W + 1;
  localparam int IDX_W = $clog2(SH_W);

  rx_state_e        state_q;
  logic [CNT_W-1:0] tick_cnt_q;
  logic [CNT_W-1:0] tick_nxt;
  logic [IDX_W-1:0] bit_idx_q;
  logic [IDX_W-1:0] last_idx;
  logic [SH_W-1:0]  shreg_q;
  logic             s_early_q;
  logic             s_mid_q;
  logic             mode9_q;
  logic             rx_prev_q;
  logic             vote;

  assign tick_nxt = (tick_cnt_q == CNT_W'(OSR - 1)) ? '0 : tick_cnt_q + 1'b1;
  assign last_idx = mode9_q ? IDX_W'(BYTE_W) : IDX_W'(BYTE_W - 1);
  assign vote     = (s_early_q & s_mid_q) | (s_early_q & rx_i) | (s_mid_q & rx_i);

  // edge history is kept on every tick, enabled or not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_prev_q <= 1'b1;
    else if (tick_i) rx_prev_q <= rx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
      shreg_q    <= '0;
      s_early_q  <= 1'b1;
      s_mid_q    <= 1'b1;
      mode9_q    <= 1'b0;
      done_o     <= 1'b0;
      word_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (!enable_i) begin
        state_q    <= ST_IDLE;
        tick_cnt_q <= '0;
        bit_idx_q  <= '0;
      end else if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (rx_prev_q && !rx_i) begin
            state_q    <= ST_START;
            tick_cnt_q <= '0;
            bit_idx_q  <= '0;
            shreg_q    <= '0;
            mode9_q    <= mode9_i;
          end
        end else begin
          tick_cnt_q <= tick_nxt;
          if (tick_nxt == CNT_W'(EARLY)) s_early_q <= rx_i;
          if (tick_nxt == CNT_W'(MID))   s_mid_q   <= rx_i;
          case (state_q)
            ST_START: begin
              if (tick_nxt == CNT_W'(MID) && rx_i) state_q <= ST_IDLE;
              else if (tick_nxt == '0)             state_q <= ST_DATA;
            end
            ST_DATA: begin
              if (tick_nxt == CNT_W'(LATE)) shreg_q[bit_idx_q] <= vote;
              if (tick_nxt == '0) begin
                if (bit_idx_q == last_idx) state_q <= ST_STOP;
                else                       bit_idx_q <= bit_idx_q + 1'b1;
              end
            end
            ST_STOP: begin
              if (tick_nxt == CNT_W'(LATE)) begin
                done_o      <= 1'b1;
                word_o.data <= shreg_q[BYTE_W-1:0];
                word_o.bit9 <= mode9_q & shreg_q[BYTE_W];
                word_o.ferr <= ~vote;
                state_q     <= ST_IDLE;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R4: a completed word is announced for exactly one cycle
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R4: a word is only announced on leaving the stop bit
  a_r4_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(state_q) == ST_STOP);
  // R3: the bit index never passes the last data bit of the frame
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_DATA |-> bit_idx_q <= last_idx);
  // R8: a low enable leaves the receiver idle
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> state_q == ST_IDLE);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush_i,
  input  logic     push_i,
  input  rx_word_t word_i,
  input  logic     pop_i,
  output rx_word_t head_o,
  output logic     valid_o,
  output logic     full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_pop;
  logic             do_push;

  assign valid_o = (count_q != '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i && valid_o;
  assign do_push = push_i && !full_o;
  assign head_o  = mem_q[rd_ptr_q];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    mem_q[e] <= '0;
      else if (do_push && wr_ptr_q == PTR_W'(e))    mem_q[e] <= word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push)
        wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)
        rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R4: the writer never offers a word to a full FIFO
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R5: ready with nothing stored leaves the FIFO empty
  a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !valid_o && !push_i && !flush_i) |=> !valid_o);
  // R10: a read with no write moves the head off the full state
  a_r10_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && full_o && !push_i && !flush_i) |=> valid_o && !full_o);
endmodule

// File: rtl/uart_rx_fifo_top.sv
module uart_rx_fifo_top
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              os_tick_i,
  input  logic              rx_enable_i,
  input  logic              mode9_i,
  input  logic              irq_enable_i,
  input  logic              rd_ready_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_bit9_o,
  output logic              rd_frame_err_o,
  output logic              rd_valid_o,
  output logic              overrun_o,
  output logic              irq_o
);
  logic     rx_sync;
  logic     frame_done;
  rx_word_t frame_word;
  rx_word_t head_word;
  logic     fifo_full;
  logic     push;
  logic     overrun_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  uart_rx_frame #(.OSR(OSR)) frame_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (rx_enable_i),
    .rx_i     (rx_sync),
    .tick_i   (os_tick_i),
    .mode9_i  (mode9_i),
    .done_o   (frame_done),
    .word_o   (frame_word)
  );

  // the gate is judged on the occupancy before any same-cycle read
  assign push = frame_done && !overrun_q && !fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     overrun_q <= 1'b0;
    else if (!rx_enable_i)                          overrun_q <= 1'b0;
    else if (frame_done && !overrun_q && fifo_full) overrun_q <= 1'b1;
  end

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (!rx_enable_i),
    .push_i  (push),
    .word_i  (frame_word),
    .pop_i   (rd_ready_i),
    .head_o  (head_word),
    .valid_o (rd_valid_o),
    .full_o  (fifo_full)
  );

  assign rd_data_o      = head_word.data;
  assign rd_bit9_o      = head_word.bit9;
  assign rd_frame_err_o = head_word.ferr;
  assign overrun_o      = overrun_q;
  assign irq_o          = rd_valid_o & irq_enable_i;

  // R7: no write reaches the FIFO while overrun is pending
  a_r7_overrun_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_q |-> !push);
  // R7: overrun holds while the enable stays high
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_q && rx_enable_i) |=> overrun_q);
  // R6: overrun only rises after a finished frame met a full FIFO
  a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_q) |-> $past(frame_done && fifo_full));
  // R5: valid only rises after a write
  a_r5_valid_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid_o) |-> $past(push));
  // R8: a low enable empties the FIFO and clears overrun
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable_i |=> (!rd_valid_o && !overrun_q));
  // R11: no request without stored data
  a_r11_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> rd_valid_o);
endmodule

// File: tb/uart_rx_fifo_top_tb.sv
module uart_rx_fifo_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_i = 1'b1;
  logic       os_tick_i = 1'b0;
  logic       rx_enable_i = 1'b0;
  logic       mode9_i = 1'b0;
  logic       irq_enable_i = 1'b0;
  logic       rd_ready_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_bit9_o;
  logic       rd_frame_err_o;
  logic       rd_valid_o;
  logic       overrun_o;
  logic       irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [9:0] exp_q [$];
  bit exp_ovr = 1'b0;

  uart_rx_fifo_top dut_i (
    .clk (clk), .rst_n (rst_n), .rx_i (rx_i), .os_tick_i (os_tick_i),
    .rx_enable_i (rx_enable_i), .mode9_i (mode9_i), .irq_enable_i (irq_enable_i),
    .rd_ready_i (rd_ready_i), .rd_data_o (rd_data_o), .rd_bit9_o (rd_bit9_o),
    .rd_frame_err_o (rd_frame_err_o), .rd_valid_o (rd_valid_o),
    .overrun_o (overrun_o), .irq_o (irq_o)
  );

  always #4 clk = ~clk;

  // one tick every four clocks: 64 clocks per bit
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
    os_tick_i <= (tick_div == 3);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // whole-output comparison against the queue model
  task automatic check_state(input string req);
    bit ev;
    @(negedge clk);
    ev = (exp_q.size() != 0);
    chk(rd_valid_o == ev, req, "valid", int'(rd_valid_o), int'(ev));
    chk(overrun_o == exp_ovr, req, "overrun", int'(overrun_o), int'(exp_ovr));
    chk(irq_o == (ev & irq_enable_i), "R11", "irq", int'(irq_o), int'(ev & irq_enable_i));
    if (ev && rd_valid_o) begin
      chk(rd_data_o == exp_q[0][7:0], req, "data", int'(rd_data_o), int'(exp_q[0][7:0]));
      chk(rd_bit9_o == exp_q[0][8], req, "bit9", int'(rd_bit9_o), int'(exp_q[0][8]));
      chk(rd_frame_err_o == exp_q[0][9], req, "ferr", int'(rd_frame_err_o), int'(exp_q[0][9]));
    end
  endtask

  task automatic drive_bit(input bit v, input bit glitch);
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      rx_i = (glitch && c >= 28 && c < 32) ? ~v : v;
    end
  endtask

  function automatic logic [9:0] expect_word(input logic [8:0] d, input bit nine, input bit stop);
    return {~stop, nine & d[8], d[7:0]};
  endfunction

  task automatic model_rx(input logic [9:0] w);
    if (!rx_enable_i) return;
    if (exp_ovr) return;
    if (exp_q.size() == 2) exp_ovr = 1'b1;
    else exp_q.push_back(w);
  endtask

  task automatic send_frame(input logic [8:0] d, input bit nine, input bit stop,
                            input int glitch_bit);
    mode9_i = nine;
    drive_bit(1'b0, 1'b0);
    for (int b = 0; b < 8; b++) drive_bit(d[b], glitch_bit == b);
    if (nine) drive_bit(d[8], glitch_bit == 8);
    drive_bit(stop, 1'b0);
    drive_bit(1'b1, 1'b0);
    model_rx(expect_word(d, nine, stop));
  endtask

  task automatic read_one();
    @(negedge clk);
    rd_ready_i = 1'b1;
    @(negedge clk);
    rd_ready_i = 1'b0;
    if (exp_q.size() != 0) void'(exp_q.pop_front());
  endtask

  task automatic toggle_enable();
    @(negedge clk);
    rx_enable_i = 1'b0;
    repeat (4) @(negedge clk);
    rx_enable_i = 1'b1;
    exp_q.delete();
    exp_ovr = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R5 R7 reset state
    check_state("R5");
    rx_enable_i = 1'b1;
    irq_enable_i = 1'b1;
    repeat (80) @(negedge clk);

    // R3 R4: single 8-bit frame, LSB first
    send_frame(9'h0A5, 1'b0, 1'b1, -1);
    check_state("R3");
    // R11: gated off
    irq_enable_i = 1'b0;
    check_state("R11");
    irq_enable_i = 1'b1;
    read_one();
    check_state("R5");

    // R5: ready on an empty FIFO is ignored, next word is intact
    read_one();
    send_frame(9'h03C, 1'b0, 1'b1, -1);
    check_state("R5");
    read_one();

    // R9 R10: two buffered words, second with a framing error
    send_frame(9'h012, 1'b0, 1'b1, -1);
    send_frame(9'h0F0, 1'b0, 1'b0, -1);
    check_state("R10");
    read_one();
    check_state("R9");

    // R6: fill, then a third frame overruns
    send_frame(9'h055, 1'b0, 1'b1, -1);
    check_state("R4");
    send_frame(9'h0AA, 1'b0, 1'b1, -1);
    check_state("R6");
    // R7: after a read a new frame still does not enter
    read_one();
    send_frame(9'h077, 1'b0, 1'b1, -1);
    check_state("R7");

    // R8: enable toggle clears overrun and flushes
    toggle_enable();
    check_state("R8");
    // R8: frames while disabled are ignored
    rx_enable_i = 1'b0;
    send_frame(9'h0C3, 1'b0, 1'b1, -1);
    check_state("R8");
    rx_enable_i = 1'b1;
    repeat (80) @(negedge clk);

    // R3 R10: 9-bit mode
    send_frame(9'h1B4, 1'b1, 1'b1, -1);
    check_state("R3");
    read_one();
    send_frame(9'h04B, 1'b1, 1'b1, -1);
    check_state("R10");
    read_one();

    // R2: short low pulse is not a start bit
    @(negedge clk);
    rx_i = 1'b0;
    repeat (8) @(negedge clk);
    rx_i = 1'b1;
    repeat (128) @(negedge clk);
    check_state("R2");
    send_frame(9'h099, 1'b0, 1'b1, -1);
    check_state("R2");
    read_one();

    // R1: one-tick glitch inside a bit is voted out
    send_frame(9'h0E7, 1'b0, 1'b1, 3);
    check_state("R1");
    read_one();
    send_frame(9'h018, 1'b0, 1'b1, 4);
    check_state("R1");
    read_one();

    // random mix
    for (int i = 0; i < 40; i++) begin
      int unsigned r;
      r = $urandom % 5;
      if (r < 2) begin
        logic [8:0] d;
        bit nine;
        bit stop;
        d = 9'($urandom);
        nine = 1'($urandom);
        stop = (($urandom % 6) != 0);
        send_frame(d, nine, stop, ($urandom % 3 == 0) ? int'($urandom % 8) : -1);
        check_state("R4");
      end else if (r == 4 && exp_ovr) begin
        toggle_enable();
        check_state("R8");
      end else begin
        read_one();
        check_state("R10");
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule